// File: doc/BRIEF.md
# Eight-Entry Word FIFO with Wrapping Level Counter

This block is a synchronous first-in first-out buffer of eight 9-bit words. It sits on the transmit or the receive side of a serial bus master. One side pushes words, either from register writes or from the shifter. The other side pops them. Each word travels through untouched. On the transmit side the data byte is placed in bits 8:1 and bit 0 is the acknowledge slot. On the receive side the consumer shifts the popped word right by one place to recover the byte.

The occupancy is reported on a level field only three bits wide. It counts 0 to 7, and with eight entries stored it wraps to 0. A separate full flag tells a full buffer from an empty one, and software takes the level as 8 while that flag is set. The free space is then 8 minus the level when full is clear. A half-full flag marks an occupancy of four or more. A soft-clear input empties the buffer in one cycle. Misuse is recorded on two sticky flags: a push into a full buffer sets overflow, and a pop from an empty one sets underflow.

Occupancy is tracked by a three-state controller:
- ST_EMPTY goes to ST_PARTIAL on an accepted push.
- ST_PARTIAL goes to ST_FULL on a push without a pop at seven entries.
- ST_PARTIAL goes to ST_EMPTY on a pop without a push at one entry.
- ST_FULL goes to ST_PARTIAL on any pop.
- Soft clear returns every state to ST_EMPTY.

Top module: `shortcnt_fifo`

## Requirements
- R1: The buffer holds up to 8 words, and they are popped in the order they were pushed.
- R2: The `level` output equals the occupancy modulo 8. It reads 0 both when empty and when holding 8 words.
- R3: `full` is 1 exactly when the buffer holds 8 words.
- R4: `half_full` is 1 exactly when the occupancy is 4 or more.
- R5: A push while `full` is 1 is dropped, even if a pop is accepted in the same cycle. It sets `overflow`, which stays 1 until reset or soft clear.
- R6: A pop while the buffer is empty leaves `pop_data` unchanged and sets `underflow`, which stays 1 until reset or soft clear.
- R7: A cycle with `soft_clr` at 1 empties the buffer and clears `overflow` and `underflow`, whatever `push` and `pop` are. `pop_data` keeps its value.
- R8: With 1 to 7 words stored, a simultaneous push and pop are both accepted and leave `level`, `full` and `half_full` unchanged.
- R9: All 9 bits of a word come out as they went in. Bits 8:1 are the byte, and bit 0, the acknowledge slot, is preserved whether it is 0 or 1.
- R10: The word taken by an accepted pop appears on `pop_data` after the clock edge that accepts the pop, and `pop_data` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of contents and flags |
| push | input | 1 | Write request |
| push_data | input | 9 | Word to write (byte in 8:1, acknowledge slot in 0) |
| pop | input | 1 | Read request |
| pop_data | output | 9 | Last word popped |
| level | output | 3 | Occupancy modulo 8 |
| full | output | 1 | Eight words stored |
| half_full | output | 1 | Four or more words stored |
| overflow | output | 1 | Sticky: push attempted while full |
| underflow | output | 1 | Sticky: pop attempted while empty |

## Verification
The hardest cases to reach are at eight entries. There the level reads 0, and a push and a pop arrive in the same cycle. The pop must be taken and the push dropped, so the buffer leaves ST_FULL and overflow is raised at once. The stimulus sweeps every starting occupancy from 0 to 8. At each one it applies, in turn, idle, push, pop and push-with-pop. It then drains the buffer past empty, so every transition and both sticky flags are reached from every fill level. A final directed case raises soft clear together with push and pop.

// File: rtl/scf_pkg.sv
package scf_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_e;
endpackage

// File: rtl/scf_store.sv
module scf_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 9,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] slot_q [DEPTH];

    // Storage array: one writer, no reset needed on the contents.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_ptr] <= wr_data;
        end
    end

    // Output register: updated only on an accepted pop (R6, R10).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= slot_q[rd_ptr];
        end
    end
endmodule

// File: rtl/scf_ctrl.sv
module scf_ctrl
    import scf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             push,
    input  logic             pop,
    output logic             wr_en,
    output logic             rd_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [OCC_W-1:0] occ,
    output occ_state_e       state
);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] OCC_LAST = OCC_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] OCC_ONE  = OCC_W'(1);

    occ_state_e       state_nxt;
    logic [OCC_W-1:0] occ_nxt;

    // Output process: accept decisions from the current state.
    always_comb begin
        wr_en = 1'b0;
        rd_en = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                wr_en = push;
            end
            ST_PARTIAL: begin
                wr_en = push;
                rd_en = pop;
            end
            ST_FULL: begin
                rd_en = pop;
            end
            default: begin
                wr_en = 1'b0;
                rd_en = 1'b0;
            end
        endcase
        if (soft_clr) begin
            wr_en = 1'b0;
            rd_en = 1'b0;
        end
    end

    // Next-state process.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: begin
                if (wr_en) state_nxt = ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (wr_en && !rd_en && occ == OCC_LAST) begin
                    state_nxt = ST_FULL;
                end else if (rd_en && !wr_en && occ == OCC_ONE) begin
                    state_nxt = ST_EMPTY;
                end
            end
            ST_FULL: begin
                if (rd_en) state_nxt = ST_PARTIAL;
            end
            default: state_nxt = ST_EMPTY;
        endcase
        if (soft_clr) state_nxt = ST_EMPTY;
    end

    always_comb begin
        occ_nxt = occ + OCC_W'(wr_en) - OCC_W'(rd_en);
        if (soft_clr) occ_nxt = '0;
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            occ   <= '0;
        end else begin
            state <= state_nxt;
            occ   <= occ_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (soft_clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/scf_status.sv
module scf_status
    import scf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             push,
    input  logic             pop,
    input  occ_state_e       state,
    input  logic [OCC_W-1:0] occ,
    output logic [PTR_W-1:0] level,
    output logic             full,
    output logic             half_full,
    output logic             overflow,
    output logic             underflow
);
    localparam logic [OCC_W-1:0] OCC_HALF = OCC_W'(DEPTH / 2);

    // Short counter: drop the top bit, so a full buffer reads 0 (R2).
    assign level     = occ[PTR_W-1:0];
    assign full      = (state == ST_FULL);
    assign half_full = (occ >= OCC_HALF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else if (soft_clr) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (push && state == ST_FULL)  overflow  <= 1'b1;
            if (pop  && state == ST_EMPTY) underflow <= 1'b1;
        end
    end
endmodule

// File: rtl/shortcnt_fifo.sv
module shortcnt_fifo
    import scf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 9,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [PTR_W-1:0] level,
    output logic             full,
    output logic             half_full,
    output logic             overflow,
    output logic             underflow
);
    logic             wr_en;
    logic             rd_en;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [OCC_W-1:0] occ;
    occ_state_e       state;

    scf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .push     (push),
        .pop      (pop),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .occ      (occ),
        .state    (state)
    );

    scf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (push_data),
        .rd_en   (rd_en),
        .rd_ptr  (rd_ptr),
        .rd_data (pop_data)
    );

    scf_status #(.DEPTH(DEPTH)) status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .push      (push),
        .pop       (pop),
        .state     (state),
        .occ       (occ),
        .level     (level),
        .full      (full),
        .half_full (half_full),
        .overflow  (overflow),
        .underflow (underflow)
    );
endmodule

// File: rtl/scf_chk.sv
module scf_chk #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 9,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_clr,
    input logic             push,
    input logic             pop,
    input logic [WIDTH-1:0] pop_data,
    input logic [PTR_W-1:0] level,
    input logic             full,
    input logic             half_full,
    input logic             overflow,
    input logic             underflow
);
    logic is_empty;
    assign is_empty = !full && (level == '0);

    AST_FULL_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (level == '0)); // R2

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !soft_clr) |=> full); // R3

    AST_FULL_IS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> half_full); // R4

    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !soft_clr) |=> overflow); // R5

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !soft_clr) |=> overflow); // R5

    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && pop && !soft_clr) |=> ($stable(pop_data) && underflow)); // R6

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (level == '0 && !full && !half_full && !overflow && !underflow)); // R7

    AST_BOTH_KEEP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !is_empty && !soft_clr)
            |=> ($stable(level) && $stable(full) && $stable(half_full))); // R8
endmodule

bind shortcnt_fifo scf_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_clr),
    .push      (push),
    .pop       (pop),
    .pop_data  (pop_data),
    .level     (level),
    .full      (full),
    .half_full (half_full),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/shortcnt_fifo_tb_top.sv
`timescale 1ns/1ps
module shortcnt_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_clr = 1'b0;
    logic       push = 1'b0;
    logic [8:0] push_data = '0;
    logic       pop = 1'b0;
    logic [8:0] pop_data;
    logic [2:0] level;
    logic       full;
    logic       half_full;
    logic       overflow;
    logic       underflow;

    int n_vec = 0;
    int n_bad = 0;

    // Reference model state, computed from the requirements.
    int         m_cnt = 0;
    logic [8:0] m_q [9];
    logic [8:0] m_out = '0;
    bit         m_ovf = 0;
    bit         m_udf = 0;

    always #2 clk = ~clk;

    shortcnt_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data), .level(level), .full(full),
        .half_full(half_full), .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R2 level"},       level,     m_cnt % 8);
        chk({tag, " R3 full"},        full,      (m_cnt == 8) ? 1 : 0);
        chk({tag, " R4 half_full"},   half_full, (m_cnt >= 4) ? 1 : 0);
        chk({tag, " R5 overflow"},    overflow,  m_ovf);
        chk({tag, " R6 underflow"},   underflow, m_udf);
        chk({tag, " R9 R10 pop_data"}, pop_data, m_out);
    endtask

    // Drive at the falling edge, let one rising edge pass, compare at the next fall.
    task automatic step(input bit p, input bit q, input logic [8:0] d,
                        input bit clr, input string tag);
        push = p; pop = q; push_data = d; soft_clr = clr;
        @(posedge clk);
        if (clr) begin
            m_cnt = 0; m_ovf = 0; m_udf = 0;
        end else begin
            bit acc_p;
            bit acc_q;
            acc_p = p && (m_cnt < 8);
            acc_q = q && (m_cnt > 0);
            if (p && m_cnt == 8) m_ovf = 1;
            if (q && m_cnt == 0) m_udf = 1;
            if (acc_q) begin
                m_out = m_q[0];
                for (int k = 0; k < 8; k++) m_q[k] = m_q[k+1];
                m_cnt--;
            end
            if (acc_p) begin
                m_q[m_cnt] = d;
                m_cnt++;
            end
        end
        @(negedge clk);
        push = 0; pop = 0; soft_clr = 0;
        check_all(tag);
    endtask

    function automatic logic [8:0] word_of(input int a, input int b, input int c);
        logic [7:0] byte_v;
        byte_v = 8'((a * 37 + b * 11 + c * 5 + 3) & 255);
        return {byte_v, 1'(b + c)};   // R9: acknowledge slot alternates 0/1
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 9; k++) m_q[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("reset R10");

        // Sweep every starting occupancy against every request combination.
        for (int L = 0; L <= 8; L++) begin
            for (int op = 0; op < 4; op++) begin
                step(0, 0, '0, 1, "R7 clear");
                for (int i = 0; i < L; i++) step(1, 0, word_of(L, i, op), 0, "R1 fill");
                unique case (op)
                    0: step(0, 0, '0, 0, "R2 idle");
                    1: step(1, 0, word_of(L, 9, op), 0, "R5 push");
                    2: step(0, 1, '0, 0, "R6 pop");
                    default: step(1, 1, word_of(L, 10, op), 0, "R8 both");
                endcase
                for (int i = 0; i < 10; i++) step(0, 1, '0, 0, "R1 drain");
            end
        end

        // Soft clear beats concurrent push and pop; pop_data is kept.
        step(0, 0, '0, 1, "R7 clear");
        for (int i = 0; i < 5; i++) step(1, 0, word_of(7, i, 1), 0, "R1 fill");
        step(0, 1, '0, 0, "R1 pop");
        step(1, 1, 9'h1AB, 1, "R7 clear with traffic");
        step(0, 1, '0, 0, "R7 empty after clear");

        // Overflow stays set across later traffic until cleared.
        step(0, 0, '0, 1, "R7 clear");
        for (int i = 0; i < 9; i++) step(1, 0, word_of(3, i, 2), 0, "R5 overfill");
        step(1, 1, 9'h0F0, 0, "R5 full push with pop");
        for (int i = 0; i < 3; i++) step(0, 1, '0, 0, "R5 sticky");
        step(0, 0, '0, 1, "R7 clear flags");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule